// File: doc/BRIEF.md
# Dual-Bank SD Data Buffer with Ready Flags

This block sits between a host bus and the data-line engine of an SD card controller. It holds data blocks of a programmed byte length in one bank (single-block mode) or in two banks used alternately (multi-block mode). In receive direction the card engine fills a bank byte by byte and the host drains it 16 bits at a time. In transmit direction the host fills a bank and the card engine drains it byte by byte.

The host reaches the buffer through a register-style port: a data port that moves one 16-bit word per strobe, and a flag register whose bits are cleared by writing 0 and left unchanged by writing 1. A DMA engine uses two valid/ready streams instead. Two status flags tell software when a whole block may be read (read-ready) or written (write-ready). A third flag records data-port accesses that have no block behind them. Blocks that arrive with a CRC or end-bit error are stored and flagged like any other block, and a status pin marks them while they are being drained.

All four data interfaces are valid/ready. A beat transfers on a rising clock edge where both valid and ready are high. The buffer drops `card_in_ready` or `dma_in_ready` when the bank it would fill holds a full block. It drops `card_out_valid` or `dma_out_valid` when the bank it would drain holds none. `dma_out_valid` and `dma_in_ready` are also held low in any cycle where the host strobes the data port, and the strobe wins. `card_out_byte` and `dma_out_data` stay stable while valid is high and ready is low. The configuration inputs `cfg_rx`, `cfg_multi` and `cfg_len` must only change while reset is asserted. `cfg_len` must lie between 1 and 2^LEN_W - 1.

Top module: `sdbuf_pingpong`

## Requirements
- R1: A synchronous active-low reset empties both banks and sets the flag register to read-ready 0, write-ready 1, illegal 0. The flag register reads back at `reg_sel`=1 with read-ready in bit 0, write-ready in bit 1 and illegal in bit 2, and all other bits 0.
- R2: A block is complete when `cfg_len` bytes are in a bank. The host side moves it in ceil(`cfg_len`/2) word beats. Byte 2k of the block travels in bits 7:0 of word k, and byte 2k+1 travels in bits 15:8.
- R3: In receive, single-block mode, read-ready sets on the clock edge that stores the last byte of a block. `card_in_ready` stays low until the host has drained that block.
- R4: In multi-block mode, blocks fill banks in the strict order 1, 2, 1, 2 and are drained in the order they were filled. Read-ready sets when either bank holds a full block. The filling side is stalled (`card_in_ready` or `dma_in_ready` low) while both banks are full.
- R5: A host write to the flag register that has 0 in bit 0 clears read-ready. The same write with 1 in bit 0 leaves read-ready unchanged.
- R6: When a DMA drain completes a block, read-ready clears. In multi-block mode it stays set instead if the other bank still holds a full block.
- R7: A received block whose last byte comes with `card_crc_err` or `card_end_err` high is still stored and still sets read-ready. `blk_err` is high while that block is the one being drained.
- R8: In transmit, write-ready sets when the card engine empties a bank. In multi-block mode, a completed host fill leaves write-ready set when the other bank is empty.
- R9: A host write to the flag register that has 0 in bit 1 clears write-ready. A DMA fill that completes a block clears write-ready unless R8 sets it again in the same cycle.
- R10: With an odd `cfg_len`, bits 15:8 of the final host write in a block are discarded, so the card engine sees exactly `cfg_len` bytes. Bits 15:8 of the final host read are 0.
- R11: A data-port strobe (`reg_sel`=0) with no block available for it sets the illegal flag and changes no data. Such a strobe is a read in transmit, a write in receive, a read with no full bank, or a write with no empty bank. The flag holds until a write to the flag register has 0 in bit 2.
- R12: In a cycle with a data-port strobe, `dma_out_valid` and `dma_in_ready` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_rx | input | 1 | 1: card to host (receive), 0: host to card (transmit) |
| cfg_multi | input | 1 | 1: two banks used alternately, 0: one bank |
| cfg_len | input | LEN_W | Block length in bytes |
| reg_sel | input | 1 | 0: data port, 1: flag register |
| reg_rd | input | 1 | Read strobe; pops one word when `reg_sel`=0 |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 16 | Host write data |
| reg_rdata | output | 16 | Host read data (data word or flag register) |
| dma_out_valid | output | 1 | DMA drain stream valid |
| dma_out_ready | input | 1 | DMA drain stream ready |
| dma_out_data | output | 16 | DMA drain stream word |
| dma_in_valid | input | 1 | DMA fill stream valid |
| dma_in_ready | output | 1 | DMA fill stream ready |
| dma_in_data | input | 16 | DMA fill stream word |
| card_in_valid | input | 1 | Card receive byte valid |
| card_in_ready | output | 1 | Card receive byte ready |
| card_in_byte | input | 8 | Card receive byte |
| card_crc_err | input | 1 | CRC error, sampled with the last byte of a block |
| card_end_err | input | 1 | End-bit error, sampled with the last byte of a block |
| card_out_valid | output | 1 | Card transmit byte valid |
| card_out_ready | input | 1 | Card transmit byte ready |
| card_out_byte | output | 8 | Card transmit byte |
| rd_ready | output | 1 | Read-ready flag |
| wr_ready | output | 1 | Write-ready flag |
| blk_err | output | 1 | The block being drained arrived with an error |

## Verification
The assertions watch, on every cycle, the properties that hold at any moment. Single-block mode never touches the second bank. The fill bank alternates on every completed block in multi-block mode. The card is stalled while both banks are full. Every completed receive raises read-ready, even with an error. A single-block DMA drain lowers it. Every card drain raises write-ready. The illegal flag holds until cleared. A data-port strobe blocks both DMA streams. What only the bench scenarios can show is the data path: byte order in the words, the arrival order of blocks across banks, the zeroed and discarded upper byte at odd lengths, and that an illegal access leaves the stored data intact.

// File: rtl/sdbb_pkg.sv
package sdbb_pkg;
  // bit positions of the flag register; software relies on these
  localparam int FLG_RD  = 0;
  localparam int FLG_WR  = 1;
  localparam int FLG_ILA = 2;

  typedef struct packed {
    logic ila;
    logic wr;
    logic rd;
  } sdbb_flags_t;
endpackage

// File: rtl/sdbb_store.sv
// Two banks of word storage; each half of a word has its own write enable
module sdbb_store #(
  parameter int LEN_W = 10
) (
  input  logic               clk,
  input  logic               we_lo,
  input  logic               we_hi,
  input  logic               wbank,
  input  logic [LEN_W-2:0]   waddr,
  input  logic [15:0]        wdata,
  input  logic               rbank,
  input  logic [LEN_W-2:0]   raddr,
  output logic [15:0]        rdata
);
  localparam int WA     = LEN_W - 1;
  localparam int WDEPTH = 1 << WA;

  logic [7:0] lo_q [2][WDEPTH];
  logic [7:0] hi_q [2][WDEPTH];

  always_ff @(posedge clk) begin
    if (we_lo) lo_q[wbank][waddr] <= wdata[7:0];
    if (we_hi) hi_q[wbank][waddr] <= wdata[15:8];
  end

  assign rdata = {hi_q[rbank][raddr], lo_q[rbank][raddr]};
endmodule

// File: rtl/sdbb_cursor.sv
// Byte position and bank pointer for one side (filling or draining)
module sdbb_cursor #(
  parameter int LEN_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             adv,
  input  logic             wide,
  input  logic             multi,
  input  logic [LEN_W-1:0] len,
  output logic [LEN_W-1:0] idx,
  output logic             bank,
  output logic             done,
  output logic             hi_ok
);
  logic [LEN_W:0] step;
  logic [LEN_W:0] nxt;

  always_comb begin
    step  = wide ? (LEN_W+1)'(2) : (LEN_W+1)'(1);
    nxt   = {1'b0, idx} + step;
    done  = adv && (nxt >= {1'b0, len});
    hi_ok = ({1'b0, idx} + (LEN_W+1)'(1)) < {1'b0, len};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      idx  <= '0;
      bank <= 1'b0;
    end else if (done) begin
      idx  <= '0;
      bank <= multi ? ~bank : 1'b0;
    end else if (adv) begin
      idx  <= nxt[LEN_W-1:0];
    end
  end
endmodule

// File: rtl/sdbb_flags.sv
// Status flags: a set event wins over any clear in the same cycle
module sdbb_flags
  import sdbb_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        sw_wr,
  input  logic [2:0]  sw_wdata,
  input  logic        rd_set,
  input  logic        rd_clr,
  input  logic        wr_set,
  input  logic        wr_clr,
  input  logic        ila_set,
  output sdbb_flags_t q
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      q.rd  <= 1'b0;
      q.wr  <= 1'b1;
      q.ila <= 1'b0;
    end else begin
      if (rd_set)                                     q.rd <= 1'b1;
      else if (rd_clr || (sw_wr && !sw_wdata[FLG_RD])) q.rd <= 1'b0;

      if (wr_set)                                     q.wr <= 1'b1;
      else if (wr_clr || (sw_wr && !sw_wdata[FLG_WR])) q.wr <= 1'b0;

      if (ila_set)                                    q.ila <= 1'b1;
      else if (sw_wr && !sw_wdata[FLG_ILA])           q.ila <= 1'b0;
    end
  end
endmodule

// File: rtl/sdbuf_pingpong.sv
module sdbuf_pingpong
  import sdbb_pkg::*;
#(
  parameter int LEN_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_rx,
  input  logic             cfg_multi,
  input  logic [LEN_W-1:0] cfg_len,
  input  logic             reg_sel,
  input  logic             reg_rd,
  input  logic             reg_wr,
  input  logic [15:0]      reg_wdata,
  output logic [15:0]      reg_rdata,
  output logic             dma_out_valid,
  input  logic             dma_out_ready,
  output logic [15:0]      dma_out_data,
  input  logic             dma_in_valid,
  output logic             dma_in_ready,
  input  logic [15:0]      dma_in_data,
  input  logic             card_in_valid,
  output logic             card_in_ready,
  input  logic [7:0]       card_in_byte,
  input  logic             card_crc_err,
  input  logic             card_end_err,
  output logic             card_out_valid,
  input  logic             card_out_ready,
  output logic [7:0]       card_out_byte,
  output logic             rd_ready,
  output logic             wr_ready,
  output logic             blk_err
);
  // producer fills banks (card in receive, host in transmit);
  // consumer drains them (host in receive, card in transmit)
  logic [1:0]       full_q, err_q;
  logic [LEN_W-1:0] p_idx, c_idx;
  logic             p_bank, c_bank, p_done, c_done, p_hi_ok, c_hi_ok;
  logic             p_adv, c_adv;
  logic             cpu_data, cpu_rd_ok, cpu_wr_ok, ila_set;
  logic             dma_rd_fire, dma_wr_fire, card_in_fire, card_out_fire;
  logic             c_avail, p_avail;
  logic             we_lo, we_hi;
  logic [15:0]      wdata, rword, host_word;
  logic             rd_set, rd_clr, wr_set, wr_clr;
  sdbb_flags_t      flg;

  assign c_avail  = full_q[c_bank];
  assign p_avail  = ~full_q[p_bank];
  assign cpu_data = (reg_rd | reg_wr) & ~reg_sel;
  assign cpu_rd_ok = reg_rd & ~reg_sel & cfg_rx & c_avail;
  assign cpu_wr_ok = reg_wr & ~reg_sel & ~cfg_rx & p_avail;
  assign ila_set  = cpu_data & ~(cpu_rd_ok | cpu_wr_ok);

  // stream handshakes; a host data strobe blocks the DMA for that cycle
  assign dma_out_valid  = cfg_rx & c_avail & ~cpu_data;
  assign dma_in_ready   = ~cfg_rx & p_avail & ~cpu_data;
  assign card_in_ready  = cfg_rx & p_avail;
  assign card_out_valid = ~cfg_rx & c_avail;

  assign dma_rd_fire   = dma_out_valid & dma_out_ready;
  assign dma_wr_fire   = dma_in_valid & dma_in_ready;
  assign card_in_fire  = card_in_valid & card_in_ready;
  assign card_out_fire = card_out_valid & card_out_ready;

  assign p_adv = cfg_rx ? card_in_fire : (cpu_wr_ok | dma_wr_fire);
  assign c_adv = cfg_rx ? (cpu_rd_ok | dma_rd_fire) : card_out_fire;

  sdbb_cursor #(.LEN_W(LEN_W)) u_pcur (
    .clk(clk), .rst_n(rst_n), .adv(p_adv), .wide(~cfg_rx), .multi(cfg_multi),
    .len(cfg_len), .idx(p_idx), .bank(p_bank), .done(p_done), .hi_ok(p_hi_ok)
  );

  sdbb_cursor #(.LEN_W(LEN_W)) u_ccur (
    .clk(clk), .rst_n(rst_n), .adv(c_adv), .wide(cfg_rx), .multi(cfg_multi),
    .len(cfg_len), .idx(c_idx), .bank(c_bank), .done(c_done), .hi_ok(c_hi_ok)
  );

  // card bytes land in the half chosen by the byte index; host words
  // write both halves except a trailing odd byte position
  always_comb begin
    if (cfg_rx) begin
      we_lo = p_adv & ~p_idx[0];
      we_hi = p_adv & p_idx[0];
      wdata = {card_in_byte, card_in_byte};
    end else begin
      we_lo = p_adv;
      we_hi = p_adv & p_hi_ok;
      wdata = cpu_wr_ok ? reg_wdata : dma_in_data;
    end
  end

  sdbb_store #(.LEN_W(LEN_W)) u_store (
    .clk(clk), .we_lo(we_lo), .we_hi(we_hi), .wbank(p_bank),
    .waddr(p_idx[LEN_W-1:1]), .wdata(wdata),
    .rbank(c_bank), .raddr(c_idx[LEN_W-1:1]), .rdata(rword)
  );

  assign host_word     = {c_hi_ok ? rword[15:8] : 8'h00, rword[7:0]};
  assign dma_out_data  = host_word;
  assign card_out_byte = c_idx[0] ? rword[15:8] : rword[7:0];
  assign reg_rdata     = reg_sel ? {13'b0, flg.ila, flg.wr, flg.rd} : host_word;

  // bank occupancy; filler and drainer never address the same bank
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      full_q <= 2'b00;
      err_q  <= 2'b00;
    end else begin
      if (p_done) begin
        full_q[p_bank] <= 1'b1;
        err_q[p_bank]  <= cfg_rx & (card_crc_err | card_end_err);
      end
      if (c_done) full_q[c_bank] <= 1'b0;
    end
  end

  assign blk_err = cfg_rx & full_q[c_bank] & err_q[c_bank];

  assign rd_set = cfg_rx & (p_done | (cfg_multi & c_done & full_q[~c_bank]));
  assign rd_clr = cfg_rx & c_done & dma_rd_fire;
  assign wr_set = ~cfg_rx & (c_done | (cfg_multi & p_done & ~full_q[~p_bank]));
  assign wr_clr = ~cfg_rx & p_done & dma_wr_fire;

  sdbb_flags u_flags (
    .clk(clk), .rst_n(rst_n), .sw_wr(reg_wr & reg_sel), .sw_wdata(reg_wdata[2:0]),
    .rd_set(rd_set), .rd_clr(rd_clr), .wr_set(wr_set), .wr_clr(wr_clr),
    .ila_set(ila_set), .q(flg)
  );

  assign rd_ready = flg.rd;
  assign wr_ready = flg.wr;
endmodule

// File: rtl/sdbb_chk.sv
module sdbb_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cfg_rx,
  input logic       cfg_multi,
  input logic       reg_sel,
  input logic       reg_rd,
  input logic       reg_wr,
  input logic [2:0] reg_wdata,
  input logic       dma_out_valid,
  input logic       dma_out_ready,
  input logic       dma_in_ready,
  input logic       card_in_ready,
  input logic       rd_ready,
  input logic       wr_ready,
  input logic       ila,
  input logic [1:0] full,
  input logic       p_done,
  input logic       c_done,
  input logic       p_bank
);
  // R3
  single_bank_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_multi |-> !full[1]);

  // R4
  pingpong_alternate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_multi && p_done |=> p_bank != $past(p_bank));

  // R4
  stall_when_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_rx && full == 2'b11 |-> !card_in_ready);

  // R6
  dma_clears_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_rx && !cfg_multi && c_done && dma_out_valid && dma_out_ready |=> !rd_ready);

  // R7
  fill_raises_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_rx && p_done |=> rd_ready);

  // R8
  drain_raises_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_rx && c_done |=> wr_ready);

  // R11
  ila_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ila && !(reg_wr && reg_sel && !reg_wdata[2]) |=> ila);

  // R12
  cpu_blocks_dma_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd || reg_wr) && !reg_sel |-> !dma_out_valid && !dma_in_ready);
endmodule

bind sdbuf_pingpong sdbb_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_rx(cfg_rx), .cfg_multi(cfg_multi),
  .reg_sel(reg_sel), .reg_rd(reg_rd), .reg_wr(reg_wr), .reg_wdata(reg_wdata[2:0]),
  .dma_out_valid(dma_out_valid), .dma_out_ready(dma_out_ready),
  .dma_in_ready(dma_in_ready), .card_in_ready(card_in_ready),
  .rd_ready(rd_ready), .wr_ready(wr_ready), .ila(flg.ila), .full(full_q),
  .p_done(p_done), .c_done(c_done), .p_bank(p_bank)
);

// File: tb/test_sdbuf_pingpong.sv
module test_sdbuf_pingpong;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_rx = 1'b1, cfg_multi = 1'b0;
  logic [9:0]  cfg_len = 10'd4;
  logic        reg_sel = 1'b1, reg_rd = 1'b0, reg_wr = 1'b0;
  logic [15:0] reg_wdata = '0, reg_rdata;
  logic        dma_out_valid, dma_out_ready = 1'b0;
  logic [15:0] dma_out_data;
  logic        dma_in_valid = 1'b0, dma_in_ready;
  logic [15:0] dma_in_data = '0;
  logic        card_in_valid = 1'b0, card_in_ready;
  logic [7:0]  card_in_byte = '0;
  logic        card_crc_err = 1'b0, card_end_err = 1'b0;
  logic        card_out_valid, card_out_ready = 1'b0;
  logic [7:0]  card_out_byte;
  logic        rd_ready, wr_ready, blk_err;

  int checks = 0;
  int fails  = 0;

  always #10 clk = ~clk;

  sdbuf_pingpong i_sdbuf_pingpong (
    .clk(clk), .rst_n(rst_n), .cfg_rx(cfg_rx), .cfg_multi(cfg_multi), .cfg_len(cfg_len),
    .reg_sel(reg_sel), .reg_rd(reg_rd), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .dma_out_valid(dma_out_valid), .dma_out_ready(dma_out_ready),
    .dma_out_data(dma_out_data), .dma_in_valid(dma_in_valid), .dma_in_ready(dma_in_ready),
    .dma_in_data(dma_in_data), .card_in_valid(card_in_valid), .card_in_ready(card_in_ready),
    .card_in_byte(card_in_byte), .card_crc_err(card_crc_err), .card_end_err(card_end_err),
    .card_out_valid(card_out_valid), .card_out_ready(card_out_ready),
    .card_out_byte(card_out_byte), .rd_ready(rd_ready), .wr_ready(wr_ready), .blk_err(blk_err)
  );

  typedef struct packed {
    logic       rx;
    logic       multi;
    logic       dma;
    logic [9:0] len;
    logic [9:0] words;
    logic [2:0] fin;   // flag register expected at the end
  } vec_t;

  localparam int NV = 7;
  localparam vec_t VECS [NV] = '{
    '{rx:1'b1, multi:1'b0, dma:1'b1, len:10'd8, words:10'd4, fin:3'b010},
    '{rx:1'b1, multi:1'b0, dma:1'b0, len:10'd5, words:10'd3, fin:3'b010},
    '{rx:1'b1, multi:1'b1, dma:1'b1, len:10'd6, words:10'd3, fin:3'b010},
    '{rx:1'b0, multi:1'b0, dma:1'b1, len:10'd8, words:10'd4, fin:3'b010},
    '{rx:1'b0, multi:1'b0, dma:1'b0, len:10'd7, words:10'd4, fin:3'b010},
    '{rx:1'b0, multi:1'b1, dma:1'b1, len:10'd3, words:10'd2, fin:3'b010},
    '{rx:1'b1, multi:1'b1, dma:1'b0, len:10'd1, words:10'd1, fin:3'b011}
  };

  function automatic logic [7:0] pat(input int b, input int i);
    return 8'(b * 37 + i * 5 + 3);
  endfunction

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_reset(input logic rx, input logic multi, input logic [9:0] len);
    rst_n = 1'b0;
    cfg_rx = rx; cfg_multi = multi; cfg_len = len;
    reg_sel = 1'b1; reg_rd = 1'b0; reg_wr = 1'b0;
    dma_out_ready = 1'b0; dma_in_valid = 1'b0; card_in_valid = 1'b0; card_out_ready = 1'b0;
    card_crc_err = 1'b0; card_end_err = 1'b0;
    tick(); tick();
    rst_n = 1'b1;
  endtask

  task automatic read_flags(output logic [2:0] f);
    reg_sel = 1'b1;
    #1;
    f = reg_rdata[2:0];
  endtask

  task automatic flag_write(input logic [2:0] v);
    reg_sel = 1'b1; reg_wdata = {13'b0, v}; reg_wr = 1'b1;
    tick();
    reg_wr = 1'b0;
  endtask

  task automatic card_send(input int b, input int len, input logic crc, input logic endb);
    for (int i = 0; i < len; i++) begin
      card_in_valid = 1'b1;
      card_in_byte  = pat(b, i);
      card_crc_err  = crc && (i == len - 1);
      card_end_err  = endb && (i == len - 1);
      #1;
      chk("R3 card_in_ready while filling", card_in_ready, 1);
      tick();
    end
    card_in_valid = 1'b0; card_crc_err = 1'b0; card_end_err = 1'b0;
  endtask

  task automatic host_read(input int b, input int len, input int words, input logic dma);
    for (int w = 0; w < words; w++) begin
      logic [15:0] exp;
      exp = {(2 * w + 1 < len) ? pat(b, 2 * w + 1) : 8'h00, pat(b, 2 * w)};
      if (dma) begin
        dma_out_ready = 1'b1;
        #1;
        chk("R2 dma_out_valid", dma_out_valid, 1);
        chk("R2/R4/R10 dma read word", dma_out_data, exp);
        tick();
        dma_out_ready = 1'b0;
      end else begin
        reg_sel = 1'b0; reg_rd = 1'b1;
        #1;
        chk("R2/R4/R10 cpu read word", reg_rdata, exp);
        tick();
        reg_rd = 1'b0; reg_sel = 1'b1;
      end
    end
  endtask

  task automatic host_write(input int b, input int len, input int words, input logic dma);
    for (int w = 0; w < words; w++) begin
      logic [15:0] d;
      d = {(2 * w + 1 < len) ? pat(b, 2 * w + 1) : 8'hEE, pat(b, 2 * w)};
      if (dma) begin
        dma_in_valid = 1'b1; dma_in_data = d;
        #1;
        chk("R2 dma_in_ready", dma_in_ready, 1);
        tick();
        dma_in_valid = 1'b0;
      end else begin
        reg_sel = 1'b0; reg_wr = 1'b1; reg_wdata = d;
        tick();
        reg_wr = 1'b0; reg_sel = 1'b1;
      end
    end
  endtask

  task automatic card_recv(input int b, input int len);
    for (int i = 0; i < len; i++) begin
      card_out_ready = 1'b1;
      #1;
      chk("R8 card_out_valid", card_out_valid, 1);
      chk("R2/R4 card_out_byte", card_out_byte, pat(b, i));
      tick();
    end
    card_out_ready = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    logic [2:0] f;
    for (int v = 0; v < NV; v++) begin
      vec_t t;
      int   len, words;
      t = VECS[v];
      len = int'(t.len);
      words = int'(t.words);
      do_reset(t.rx, t.multi, t.len);
      read_flags(f);
      chk("R1 flags after reset", f, 3'b010);
      if (t.rx) begin
        chk("R1 card_in_ready after reset", card_in_ready, 1);
        card_send(0, len, 1'b0, 1'b0);
        read_flags(f);
        chk("R3 read-ready after block", f[0], 1);
        if (t.multi) card_send(1, len, 1'b0, 1'b0);
        chk("R3/R4 card stalled when banks full", card_in_ready, 0);
        if (!t.dma) begin
          flag_write(3'b110);
          read_flags(f);
          chk("R5 sw clear read-ready", f, 3'b010);
        end
        host_read(0, len, words, t.dma);
        if (t.dma) begin
          read_flags(f);
          chk("R6 read-ready after dma drain", f[0], t.multi);
        end
        if (t.multi) host_read(1, len, words, t.dma);
        chk("R2 bank empty after ceil(len/2) beats", dma_out_valid, 0);
        chk("R3 card ready after drain", card_in_ready, 1);
      end else begin
        chk("R1 dma_in_ready after reset", dma_in_ready, 1);
        if (!t.dma) begin
          flag_write(3'b101);
          read_flags(f);
          chk("R9 sw clear write-ready", f[1], 0);
        end
        host_write(0, len, words, t.dma);
        read_flags(f);
        if (t.dma) chk("R9/R8 write-ready after dma fill", f[1], t.multi);
        else       chk("R9 write-ready stays clear", f[1], 0);
        if (t.multi) begin
          host_write(1, len, words, t.dma);
          #1;
          chk("R4 dma fill stalled when both full", dma_in_ready, 0);
        end
        card_recv(0, len);
        read_flags(f);
        chk("R8 write-ready after card drain", f[1], 1);
        if (t.multi) card_recv(1, len);
        chk("R10 card sees exactly len bytes", card_out_valid, 0);
      end
      read_flags(f);
      chk("R1 final flag vector", f, t.fin);
    end

    // R1: reset in the middle empties the banks
    do_reset(1'b1, 1'b0, 10'd4);
    card_send(3, 4, 1'b0, 1'b0);
    do_reset(1'b1, 1'b0, 10'd4);
    read_flags(f);
    chk("R1 flags after mid-run reset", f, 3'b010);
    chk("R1 banks emptied by reset", card_in_ready, 1);

    // R7: errored blocks are kept and flagged; R5: writing 1 leaves read-ready
    card_send(4, 4, 1'b1, 1'b0);
    read_flags(f);
    chk("R7 read-ready despite CRC error", f[0], 1);
    chk("R7 blk_err on errored block", blk_err, 1);
    flag_write(3'b111);
    read_flags(f);
    chk("R5 write of 1 leaves read-ready", f[0], 1);
    host_read(4, 4, 2, 1'b1);
    chk("R7 blk_err after drain", blk_err, 0);
    card_send(5, 4, 1'b0, 1'b1);
    chk("R7 blk_err on end-bit error", blk_err, 1);
    host_read(5, 4, 2, 1'b1);
    card_send(6, 4, 1'b0, 1'b0);
    chk("R7 blk_err clean block", blk_err, 0);
    host_read(6, 4, 2, 1'b1);

    // R11: read with no block, then a write in receive direction
    reg_sel = 1'b0; reg_rd = 1'b1;
    tick();
    reg_rd = 1'b0;
    read_flags(f);
    chk("R11 illegal flag after empty read", f[2], 1);
    chk("R11 illegal read left no block", dma_out_valid, 0);
    flag_write(3'b011);
    read_flags(f);
    chk("R11 illegal flag cleared", f[2], 0);
    card_send(7, 4, 1'b0, 1'b0);
    reg_sel = 1'b0; reg_wr = 1'b1; reg_wdata = 16'hFFFF;
    tick();
    reg_wr = 1'b0;
    read_flags(f);
    chk("R11 illegal flag after write in receive", f[2], 1);

    // R12: host strobe wins over DMA; R11: data untouched by the bad write
    dma_out_ready = 1'b1; reg_sel = 1'b0; reg_rd = 1'b1;
    #1;
    chk("R12 dma_out_valid low during host strobe", dma_out_valid, 0);
    chk("R11 data intact after illegal write", reg_rdata, {pat(7, 1), pat(7, 0)});
    tick();
    reg_rd = 1'b0;
    #1;
    chk("R12 dma resumes at next word", dma_out_valid, 1);
    chk("R12 dma word after host pop", dma_out_data, {pat(7, 3), pat(7, 2)});
    tick();
    dma_out_ready = 1'b0;
    reg_sel = 1'b1;

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule